// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block turns a 4-bit encoded external interrupt level into per-source request lines for a chain of fifteen interrupt sources inside an interrupt controller core. A level of zero means nothing is requested, so every source in the chain is released. A nonzero level selects exactly one source. Any source that was asserted for an earlier level is dropped when the new level is taken.

The chain index is the bitwise inverse of the level. Level 15 is the most urgent and drives chain position 0. Level 1 is the least urgent and drives position 14. Alongside the request lines, the block gives the selected source a forced enable. This lets the controller unmask an external level source right away. The enable is forced only while the controller reports that source as not yet enabled.

Both output vectors are registered. A level and an enable pattern sampled at one clock edge appear on the outputs from that edge onward. Reset is asynchronous on assertion and synchronised on release.

Top module: `irl_level_decoder`

## Requirements
- R1: While reset is asserted, every bit of `src_assert_o` and `src_force_en_o` is 0.
- R2: A sampled level of 0 leaves every bit of `src_assert_o` at 0.
- R3: A sampled nonzero level L sets only bit (L XOR 15) of `src_assert_o`, so level 15 drives bit 0 and level 1 drives bit 14.
- R4: At most one bit of `src_assert_o` is 1. When the level changes, the previously selected bit returns to 0 together with the new selection.
- R5: Bit i of `src_force_en_o` is 1 exactly when bit i of `src_assert_o` is being set for the sampled level and bit i of `src_en_i` was 0 at that edge. Otherwise it is 0.
- R6: Outputs change only at a rising clock edge. A new level or enable pattern driven between edges is not visible until the next rising edge has sampled it.
- R7: While the level is held, the selected request stays high across cycles, and the forced enable follows the current value of `src_en_i` for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irl_level_i | input | 4 | Encoded interrupt level; 0 means no request |
| src_en_i | input | 15 | Current enabled state of each chain source, from the controller |
| src_assert_o | output | 15 | Registered one-hot request line per chain source |
| src_force_en_o | output | 15 | Registered enable-forcing line per chain source |

## Verification
The bench sweeps all sixteen levels three times, each time with a different enable pattern: all sources disabled, all enabled, and alternating. With the enables clear, every selected bit must show up on the force output, which confirms the inverted index map on both outputs. With the enables set, the force output must stay silent. The alternating pattern separates a correct per-bit gate from a wrong bit or an inverted gate. Stepping through the levels in order, and then jumping from high levels straight to zero, shows whether earlier selections are released. A sample taken between edges checks the register timing, a held level with the enable toggled checks steady-state tracking, and an asynchronous reset in the middle of the run checks the clear.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned NSRC  = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [NSRC-1:0]  srcvec_t;

  typedef struct packed {
    srcvec_t req;
    srcvec_t force_en;
  } irl_out_t;
endpackage

// File: rtl/irl_rst_sync.sv
module irl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irl_index_decode.sv
module irl_index_decode
  import irl_pkg::*;
#(
  parameter int unsigned LW = LVL_W,
  localparam int unsigned NS = (1 << LW) - 1
) (
  input  logic [LW-1:0] level,
  output logic [NS-1:0] sel
);
  // chain index is the bitwise inverse of the level; level 0 maps past the chain
  localparam logic [LW-1:0] INV_MASK = '1;

  for (genvar i = 0; i < NS; i++) begin : g_sel
    localparam logic [LW-1:0] LVL_FOR_I = LW'(i) ^ INV_MASK;
    assign sel[i] = (level == LVL_FOR_I);
  end
endmodule

// File: rtl/irl_enable_gate.sv
module irl_enable_gate #(
  parameter int unsigned NS = 15
) (
  input  logic [NS-1:0] sel,
  input  logic [NS-1:0] en_state,
  output logic [NS-1:0] force_en
);
  for (genvar i = 0; i < NS; i++) begin : g_gate
    assign force_en[i] = sel[i] & ~en_state[i];
  end
endmodule

// File: rtl/irl_out_reg.sv
module irl_out_reg
  import irl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irl_out_t nxt,
  output irl_out_t cur
);
  irl_out_t q;
  logic     upd_en;

  always_comb begin
    upd_en = (nxt != q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= nxt;
  end

  assign cur = q;
endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder
  import irl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irl_level_i,
  input  logic [NSRC-1:0]  src_en_i,
  output logic [NSRC-1:0]  src_assert_o,
  output logic [NSRC-1:0]  src_force_en_o
);
  logic     rst_core_n;
  srcvec_t  sel;
  srcvec_t  force_nxt;
  irl_out_t out_nxt;
  irl_out_t out_cur;

  irl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  irl_index_decode #(.LW(LVL_W)) u_decode (
    .level (irl_level_i),
    .sel   (sel)
  );

  irl_enable_gate #(.NS(NSRC)) u_gate (
    .sel      (sel),
    .en_state (src_en_i),
    .force_en (force_nxt)
  );

  always_comb begin
    out_nxt.req      = sel;
    out_nxt.force_en = force_nxt;
  end

  irl_out_reg u_out_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .nxt   (out_nxt),
    .cur   (out_cur)
  );

  assign src_assert_o   = out_cur.req;
  assign src_force_en_o = out_cur.force_en;
endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk
  import irl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rst_core_n,
  input logic [LVL_W-1:0] irl_level_i,
  input logic [NSRC-1:0]  src_en_i,
  input logic [NSRC-1:0]  src_assert_o,
  input logic [NSRC-1:0]  src_force_en_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (src_assert_o == '0 && src_force_en_o == '0));

  p_level_zero_release_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irl_level_i == '0) |=> (src_assert_o == '0));

  p_top_level_bit0_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irl_level_i == '1) |=> (src_assert_o == NSRC'(1)));

  p_single_request_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(src_assert_o));

  p_force_within_request_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((src_force_en_o & ~src_assert_o) == '0));

  p_force_blocked_when_enabled_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irl_level_i == LVL_W'(1) && src_en_i[NSRC-1]) |=> !src_force_en_o[NSRC-1]);

  p_held_level_steady_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irl_level_i != '0 && $stable(irl_level_i) && $past(rst_core_n)) |=> $stable(src_assert_o));
endmodule

bind irl_level_decoder irl_level_decoder_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_core_n     (rst_core_n),
  .irl_level_i    (irl_level_i),
  .src_en_i       (src_en_i),
  .src_assert_o   (src_assert_o),
  .src_force_en_o (src_force_en_o)
);

// File: tb/irl_level_decoder_bench.sv
module irl_level_decoder_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  lvl;
  logic [14:0] en;
  logic [14:0] req;
  logic [14:0] frc;

  int tests  = 0;
  int fails  = 0;
  bit done   = 0;

  irl_level_decoder u_irl_level_decoder (
    .clk            (clk),
    .rst_n          (rst_n),
    .irl_level_i    (lvl),
    .src_en_i       (en),
    .src_assert_o   (req),
    .src_force_en_o (frc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [14:0] exp_req(input logic [3:0] l);
    if (l == 4'd0) return 15'd0;
    return 15'd1 << (15 - int'(l));
  endfunction

  task automatic check(input string rq, input logic [14:0] act, input logic [14:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lvl   = 4'd0;
    en    = '0;
    repeat (3) @(negedge clk);
    check("R1 reset req", req, 15'd0);
    check("R1 reset force", frc, 15'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int p = 0; p < 3; p++) begin
      for (int l = 0; l < 16; l++) begin
        logic [14:0] e;
        e   = (p == 0) ? 15'h0000 : (p == 1) ? 15'h7FFF : 15'h5555;
        lvl = 4'(l);
        en  = e;
        @(negedge clk);
        check(l == 0 ? "R2 level zero" : "R3 R4 index map", req, exp_req(4'(l)));
        check("R5 force gate", frc, exp_req(4'(l)) & ~e);
      end
    end

    for (int l = 15; l > 0; l -= 4) begin
      lvl = 4'(l);
      en  = '0;
      @(negedge clk);
      check("R4 new level", req, exp_req(4'(l)));
      lvl = 4'd0;
      @(negedge clk);
      check("R2 release", req, 15'd0);
    end

    lvl = 4'd6;
    en  = '0;
    @(negedge clk);
    lvl = 4'd11;
    en  = 15'h7FFF;
    #1;
    check("R6 before edge req", req, exp_req(4'd6));
    check("R6 before edge force", frc, exp_req(4'd6));
    @(negedge clk);
    check("R6 after edge req", req, exp_req(4'd11));
    check("R6 after edge force", frc, 15'd0);

    lvl = 4'd9;
    en  = '0;
    @(negedge clk);
    check("R7 hold start", frc, exp_req(4'd9));
    en = exp_req(4'd9);
    @(negedge clk);
    check("R7 hold req", req, exp_req(4'd9));
    check("R7 hold force off", frc, 15'd0);
    en = '0;
    @(negedge clk);
    check("R7 hold req again", req, exp_req(4'd9));
    check("R7 hold force on", frc, exp_req(4'd9));

    #1 rst_n = 1'b0;
    #1;
    check("R1 async req", req, 15'd0);
    check("R1 async force", frc, 15'd0);
    @(negedge clk);
    lvl = 4'd0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule